// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a first-in first-out buffer, 64 words deep and 4 bits wide. It is driven by two strobes instead of enable signals. A word on the data inputs is captured when the shift-in strobe rises. A word is removed when the shift-out strobe falls. Both strobes are synchronous to the system clock, and the block finds their edges by comparing each strobe with its value in the previous cycle.

The output stage is loaded without any read request. The oldest stored word falls through to the data outputs by itself. The last word removed stays on the outputs until a newer word arrives or reset clears them. Two flags give the status. `inReady` means another word can be accepted. `outReady` means valid data is on the outputs. Each flag drops while its own strobe is high. When a strobe is held high across the full or empty boundary, its flag shows a single one-cycle pulse and the word transfer happens on its own.

An active-low reset empties the buffer and clears the outputs to zero. A word present on the inputs while shift-in is still high at reset release is captured.

Top module: `sfifo_fallthru`

## Requirements
- R1: While `rstN` is low and after it is released with both strobes low, the buffer is empty, `dataOut` is 4'h0, `outReady` is 0 and `inReady` is 1.
- R2: A rising edge of `shiftIn` (high this cycle, low the cycle before) stores `dataIn` if fewer than 64 words are held. A rising edge while 64 words are held stores nothing.
- R3: The first word written into an empty buffer does not reach `dataOut` while `shiftIn` stays high. It appears on `dataOut` with `outReady` high on the clock edge after `shiftIn` is seen low.
- R4: A falling edge of `shiftOut` removes the word on the outputs. The next stored word appears one clock later, and words leave in the order they were written.
- R5: `outReady` is 0 while `shiftOut` is high (outside the R8 pulse) and while the buffer is empty. Falling edges of `shiftOut` on an empty buffer have no effect.
- R6: `inReady` is 0 while `shiftIn` is high (outside the R9 pulse) and while 64 words are held.
- R7: `dataOut` keeps the last word removed until a new word falls through or reset occurs.
- R8: With the buffer empty and `shiftOut` held high, a word that falls through raises `outReady` for exactly one cycle and is then removed on its own.
- R9: With the buffer full and `shiftIn` held high, a falling `shiftOut` raises `inReady` for exactly one cycle. During that cycle `dataIn` is captured without a new rising edge.
- R10: If `shiftIn` is high when `rstN` is released, `dataIn` is stored and `inReady` stays 0 until `shiftIn` falls. If `shiftIn` fell before the release, nothing is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| shiftIn | input | 1 | Write strobe; acts on its rising edge |
| shiftOut | input | 1 | Read strobe; acts on its falling edge |
| dataIn | input | 4 | Word to be written |
| dataOut | output | 4 | Output stage, oldest stored word |
| inReady | output | 1 | Another word can be accepted |
| outReady | output | 1 | Valid data on dataOut |

## Verification
The hardest case to reach is the automatic capture at the full boundary. The buffer has to be filled to exactly 64 words, and then `shiftIn` has to be raised and held so that its rising edge is rejected. A single `shiftOut` pulse then has to free one slot. The bench builds this state through 64 ordinary writes. It samples `inReady` in the single cycle after the read, and then drains the whole buffer to confirm that the held input word came out last. The mirror case at the empty boundary holds `shiftOut` high across a fall-through and checks the one-cycle `outReady` pulse together with the held output word.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic pushEn;   // write dataIn at the write pointer
    logic popEn;    // advance the read pointer
    logic loadOut;  // copy the head word into the output stage
  } fifoStrobe_t;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftIn,
  input  logic        shiftOut,
  output fifoStrobe_t strobe,
  output logic        inReady,
  output logic        outReady
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic             siPrev, soPrev;
  logic [CNT_W-1:0] count;
  logic             shown;      // head word is in the output stage
  logic             justShown;  // output stage loaded last cycle
  logic             justRoom;   // a slot freed from full last cycle

  logic siRise, soFall, notFull, pushEv, popEv, loadEv;

  always_comb begin
    siRise  = shiftIn & ~siPrev;
    soFall  = ~shiftOut & soPrev;
    notFull = (count != FULL_CNT);
    popEv   = shown & (soFall | (justShown & shiftOut));
    pushEv  = notFull & (siRise | (justRoom & shiftIn));
    // a lone word just written waits for shiftIn to drop
    loadEv  = ~shown & (count != '0) & ~((count == ONE_CNT) & shiftIn);
    strobe.pushEn  = pushEv;
    strobe.popEn   = popEv;
    strobe.loadOut = loadEv;
    outReady = shown & (~shiftOut | justShown);
    inReady  = notFull & (~shiftIn | justRoom);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siPrev    <= 1'b0;
      soPrev    <= 1'b0;
      count     <= '0;
      shown     <= 1'b0;
      justShown <= 1'b0;
      justRoom  <= 1'b0;
    end else begin
      siPrev    <= shiftIn;
      soPrev    <= shiftOut;
      count     <= count + CNT_W'(pushEv) - CNT_W'(popEv);
      justShown <= loadEv;
      justRoom  <= popEv & ~pushEv & (count == FULL_CNT);
      if (loadEv)     shown <= 1'b1;
      else if (popEv) shown <= 1'b0;
    end
  end

  // R2: the count never exceeds the capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R2: a rising edge while full leaves the buffer full
  a_r2_full_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT && siRise && !popEv) |=> (count == FULL_CNT));
  // R5: an empty buffer never reports ready data and never pops
  a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (!outReady && !strobe.popEn));
  // R8: output-ready seen with shiftOut high is a single-cycle pulse
  a_r8_or_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && shiftOut) |=> !outReady);
  // R9: input-ready seen with shiftIn high is a single-cycle pulse
  a_r9_ir_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && shiftIn) |=> !inReady);
endmodule

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [DATA_W-1:0] outReg;

  generate
    if ((1 << ADDR_W) == DEPTH) begin : g_pow2
      assign wrNext = wrPtr + ADDR_W'(1);
      assign rdNext = rdPtr + ADDR_W'(1);
    end else begin : g_wrap
      assign wrNext = (wrPtr == LAST_ADDR) ? '0 : wrPtr + ADDR_W'(1);
      assign rdNext = (rdPtr == LAST_ADDR) ? '0 : rdPtr + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.pushEn) store[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      outReg <= '0;
    end else begin
      if (strobe.pushEn)  wrPtr  <= wrNext;
      if (strobe.popEn)   rdPtr  <= rdNext;
      if (strobe.loadOut) outReg <= store[rdPtr];
    end
  end

  assign dataOut = outReg;

  // R7: the output word changes only when the control loads it
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> $stable(dataOut));
endmodule

// File: rtl/sfifo_fallthru.sv
module sfifo_fallthru
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftIn,
  input  logic              shiftOut,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              inReady,
  output logic              outReady
);
  fifoStrobe_t strobe;

  sfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .strobe(strobe), .inReady(inReady), .outReady(outReady)
  );

  sfifo_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/sim_sfifo_fallthru.sv
module sim_sfifo_fallthru;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shiftIn = 1'b0;
  logic       shiftOut = 1'b0;
  logic [3:0] dataIn = 4'h0;
  logic [3:0] dataOut;
  logic       inReady, outReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] q[$];
  logic [3:0] lastShown = 4'h0;

  // bit4 = 1 write, 0 read; bits 3:0 = data for a write
  localparam logic [4:0] VEC [16] = '{
    5'h13, 5'h17, 5'h00, 5'h1C, 5'h11, 5'h00, 5'h00, 5'h00,
    5'h00, 5'h1F, 5'h10, 5'h00, 5'h18, 5'h00, 5'h00, 5'h15
  };

  sfifo_fallthru u0 (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .dataIn(dataIn), .dataOut(dataOut), .inReady(inReady), .outReady(outReady)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushW(input logic [3:0] d);
    @(negedge clk); dataIn = d; shiftIn = 1'b1;
    @(negedge clk); shiftIn = 1'b0;
    cyc(2);
  endtask

  task automatic popW();
    @(negedge clk); shiftOut = 1'b1;
    @(negedge clk); shiftOut = 1'b0;
    cyc(2);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    q.delete();
    lastShown = 4'h0;
  endtask

  task automatic modelCheck(input string req);
    if (q.size() > 0) lastShown = q[0];
    chk({7'd0, outReady}, {7'd0, (q.size() > 0)}, req);
    chk({7'd0, inReady}, {7'd0, (q.size() < 64)}, req);
    chk({4'd0, dataOut}, {4'd0, lastShown}, req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(2);
    chk({7'd0, outReady}, 8'd0, "R1 outReady in reset");
    chk({7'd0, inReady}, 8'd1, "R1 inReady in reset");
    chk({4'd0, dataOut}, 8'd0, "R1 dataOut in reset");
    rstN = 1'b1;
    cyc(2);
    chk({7'd0, outReady}, 8'd0, "R1 outReady after release");

    // R3: first word held back while shiftIn high
    @(negedge clk); dataIn = 4'h6; shiftIn = 1'b1;
    @(negedge clk);
    chk({7'd0, outReady}, 8'd0, "R3 not shown while shiftIn high");
    chk({4'd0, dataOut}, 8'd0, "R3 dataOut unchanged while shiftIn high");
    chk({7'd0, inReady}, 8'd0, "R6 inReady low while shiftIn high");
    shiftIn = 1'b0;
    @(negedge clk);
    chk({7'd0, outReady}, 8'd1, "R3 outReady after shiftIn low");
    chk({4'd0, dataOut}, 8'h06, "R3 word fell through");
    shiftOut = 1'b1;
    @(negedge clk);
    chk({7'd0, outReady}, 8'd0, "R5 outReady low while shiftOut high");
    shiftOut = 1'b0;
    cyc(2);
    chk({7'd0, outReady}, 8'd0, "R4 empty after read");
    chk({4'd0, dataOut}, 8'h06, "R7 last word held");
    lastShown = 4'h6;

    // table-driven R2/R4/R5/R7 against the queue model
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][4]) begin
        pushW(VEC[i][3:0]);
        if (q.size() < 64) q.push_back(VEC[i][3:0]);
        modelCheck("R2 table write");
      end else begin
        popW();
        if (q.size() > 0) void'(q.pop_front());
        modelCheck("R4 table read");
      end
    end

    // R2/R6/R9: fill to 64, overflow ignored, automatic capture
    doReset();
    cyc(1);
    for (int i = 0; i < 64; i++) pushW(4'(i));
    chk({7'd0, inReady}, 8'd0, "R6 inReady low when full");
    @(negedge clk); dataIn = 4'hA; shiftIn = 1'b1;
    cyc(2);
    chk({7'd0, inReady}, 8'd0, "R2 full rising edge rejected");
    @(negedge clk); shiftOut = 1'b1;
    @(negedge clk); shiftOut = 1'b0;
    @(negedge clk);
    chk({7'd0, inReady}, 8'd1, "R9 inReady pulse");
    @(negedge clk);
    chk({7'd0, inReady}, 8'd0, "R9 inReady back low after capture");
    shiftIn = 1'b0;
    cyc(2);
    chk({7'd0, inReady}, 8'd0, "R9 buffer full again");
    chk({4'd0, dataOut}, 8'h01, "R4 next word after read");
    for (int i = 1; i < 64; i++) begin
      if (dataOut !== 4'(i)) chk({4'd0, dataOut}, {4'd0, 4'(i)}, "R4 drain order");
      popW();
    end
    chk({4'd0, dataOut}, 8'h0A, "R9 captured word last");
    popW();
    chk({7'd0, outReady}, 8'd0, "R5 empty after drain");

    // R5: read edge on empty buffer has no effect
    popW();
    pushW(4'h3);
    chk({4'd0, dataOut}, 8'h03, "R5 empty read ignored");
    popW();

    // R8: shiftOut held high across a fall-through
    @(negedge clk); shiftOut = 1'b1;
    @(negedge clk); dataIn = 4'h5; shiftIn = 1'b1;
    @(negedge clk); shiftIn = 1'b0;
    @(negedge clk);
    chk({7'd0, outReady}, 8'd1, "R8 outReady pulse");
    chk({4'd0, dataOut}, 8'h05, "R8 pulse data");
    @(negedge clk);
    chk({7'd0, outReady}, 8'd0, "R8 pulse one cycle");
    chk({4'd0, dataOut}, 8'h05, "R7 held after auto read");
    shiftOut = 1'b0;
    cyc(2);
    chk({7'd0, outReady}, 8'd0, "R8 word consumed");

    // R10: shiftIn high at reset release stores the word
    @(negedge clk); rstN = 1'b0; dataIn = 4'h9; shiftIn = 1'b1;
    cyc(2);
    chk({4'd0, dataOut}, 8'h00, "R1 reset clears dataOut");
    rstN = 1'b1;
    @(negedge clk);
    chk({7'd0, inReady}, 8'd0, "R10 inReady low after release");
    shiftIn = 1'b0;
    @(negedge clk);
    chk({7'd0, inReady}, 8'd1, "R10 inReady high after shiftIn falls");
    chk({4'd0, dataOut}, 8'h09, "R10 word stored at release");

    // R10: shiftIn dropped before release stores nothing
    @(negedge clk); rstN = 1'b0; shiftIn = 1'b1;
    @(negedge clk); shiftIn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    cyc(3);
    chk({7'd0, outReady}, 8'd0, "R10 nothing stored");
    chk({4'd0, dataOut}, 8'h00, "R10 dataOut still clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule